// File: doc/BRIEF.md
# Structured E1 Timeslot Cell Packer

This block receives a framed E1 stream one octet per handshake. Each frame has 32 timeslots, and a start marker flags the octet of timeslot 0. A 32-bit selection mask chooses the timeslots to keep. The block collects the octets of those timeslots in the order they arrive, across as many frames as needed, into a 47-octet AAL1 payload. It then sends a 48-octet SAR-PDU on a valid/ready byte stream: one protected header octet followed by the 47 payload octets.

Timeslot 0 carries framing, so the block never keeps it. A cell can leave early, before 47 octets are gathered, in two ways: a programmable fill limit is reached, or a flush request arrives. In either case the unused payload positions are filled with 0xFF. This gives up some efficiency for lower latency, which suits delay-sensitive voice channels. While a cell is going out, the input side is held off with backpressure, so no octet is lost.

Top module: `e1_slot_packer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the first cell sent carries sequence count 0.
- R2: The octet accepted with in_sof high is timeslot 0. It is never placed in a payload, even when slot_mask bit 0 is set.
- R3: The octet accepted k handshakes after the in_sof octet is timeslot k. It is packed exactly when slot_mask bit k is 1. Packed octets appear in payload positions 1 to 47 in the order they were accepted, across frame boundaries.
- R4: Every cell is 48 octets. The header comes first, then 47 payload octets, and out_last is high on the 48th octet only.
- R5: The header bit layout is fixed. Bit 7 is CSI. Bits 6:4 hold the sequence count. Bits 3:1 hold the CRC remainder of header bits 7:4 (MSB first) times x^3, divided by x^3+x+1. Bit 0 is set so that the whole octet has even parity.
- R6: CSI is 1 when the sequence count is even and 0 when it is odd.
- R7: The sequence count goes up by one, modulo 8, for every cell sent.
- R8: A cell starts on the cycle after the packed octet that brings the count to the fill limit. A fill_limit of 0 or above 47 counts as 47. Payload positions after the last packed octet carry 0xFF.
- R9: A flush_req cycle starts a cell when at least one octet is held, counting an octet packed in that same cycle. The cell is padded as in R8. A flush_req with nothing held has no effect.
- R10: in_ready is 0 from the cycle after a cell is triggered until the handshake of its last octet. Every offered octet is eventually accepted exactly once.
- R11: While out_valid is 1 and out_ready is 0, out_data and out_valid stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_mask | input | 32 | Bit k selects timeslot k for packing |
| fill_limit | input | 6 | Octet count that triggers a cell (0 or >47 means 47) |
| flush_req | input | 1 | Send the partial payload now |
| in_valid | input | 1 | Input octet valid |
| in_ready | output | 1 | Input octet can be taken |
| in_data | input | 8 | Input timeslot octet |
| in_sof | input | 1 | Marks the octet of timeslot 0 |
| out_valid | output | 1 | Output octet valid |
| out_ready | input | 1 | Downstream takes the octet |
| out_data | output | 8 | SAR-PDU octet |
| out_last | output | 1 | Marks the final octet of a cell |

## Verification
A cell's header is present one cycle after the rising edge that accepted the triggering octet or flush request. Each later octet appears one cycle after the handshake of the one before it. in_ready returns one cycle after the handshake of the last octet. The bench drives inputs in tasks and samples every output on the falling edge that follows those edges, so each comparison lands in the cycle where the result is due. During a stall, the bench holds out_ready low for two extra falling edges and compares the held octet each time.

// File: rtl/e1_slot_packer.sv
module e1_slot_packer #(
  parameter int SLOTS   = 32,
  parameter int PAYLOAD = 47
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SLOTS-1:0]                 slot_mask,
  input  logic [$clog2(PAYLOAD+2)-1:0]     fill_limit,
  input  logic                             flush_req,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [7:0]                       in_data,
  input  logic                             in_sof,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [7:0]                       out_data,
  output logic                             out_last
);
  localparam int SW = $clog2(SLOTS);
  localparam int IW = $clog2(PAYLOAD + 2);
  localparam logic [IW-1:0] FULL = IW'(PAYLOAD);

  logic [SW-1:0] slot_q;
  logic [IW-1:0] cnt_q, idx_q;
  logic          emit_q;
  logic [2:0]    seq_q;
  logic [7:0]    pay_q [PAYLOAD];

  function automatic logic [2:0] crc3(input logic [3:0] d);
    logic [2:0] r;
    logic       fb;
    r = '0;
    for (int i = 3; i >= 0; i--) begin
      fb = d[i] ^ r[2];
      r  = {r[1], r[0] ^ fb, fb};
    end
    return r;
  endfunction

  logic [SW-1:0] cur_slot;
  logic          take, keep, fire;
  logic [IW-1:0] cnt_nx, lim;
  logic [3:0]    hdr_hi;
  logic [6:0]    hdr_7;

  assign take     = in_valid && in_ready;
  assign cur_slot = in_sof ? '0 : slot_q;
  assign keep     = take && slot_mask[cur_slot] && (cur_slot != '0);
  assign cnt_nx   = cnt_q + IW'(keep);
  assign lim      = (fill_limit == '0 || fill_limit > FULL) ? FULL : fill_limit;
  assign fire     = !emit_q && ((cnt_nx == lim) || (flush_req && cnt_nx != '0));

  assign hdr_hi   = {~seq_q[0], seq_q};
  assign hdr_7    = {hdr_hi, crc3(hdr_hi)};

  assign in_ready  = !emit_q;
  assign out_valid = emit_q;
  assign out_last  = emit_q && (idx_q == FULL);
  assign out_data  = (idx_q == '0)   ? {hdr_7, ^hdr_7} :
                     (idx_q <= cnt_q) ? pay_q[idx_q - 1'b1] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      emit_q <= 1'b0;
      seq_q  <= '0;
    end else begin
      if (take)
        slot_q <= (cur_slot == SW'(SLOTS - 1)) ? '0 : cur_slot + 1'b1;
      if (!emit_q) begin
        cnt_q <= cnt_nx;
        if (fire) begin
          emit_q <= 1'b1;
          idx_q  <= '0;
        end
      end else if (out_ready) begin
        if (idx_q == FULL) begin
          emit_q <= 1'b0;
          cnt_q  <= '0;
          seq_q  <= seq_q + 3'd1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (keep) pay_q[cnt_q] <= in_data;

  p_ts0_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_sof) |=> (cnt_q == $past(cnt_q)));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  p_hdr_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idx_q == '0) |-> (^out_data == 1'b0));

  p_csi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && idx_q == '0) |-> (out_data[7] != out_data[4]));

  p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (seq_q == $past(seq_q) + 3'd1));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/e1_slot_packer_tb_top.sv
`timescale 1ns/1ps
module e1_slot_packer_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [31:0] slot_mask = '0;
  logic [5:0]  fill_limit = '0;
  logic        flush_req = 0, in_valid = 0, in_sof = 0, out_ready = 0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_last;
  logic [7:0]  out_data;

  always #2 clk = ~clk;

  e1_slot_packer dut_i (
    .clk(clk), .rst_n(rst_n), .slot_mask(slot_mask), .fill_limit(fill_limit),
    .flush_req(flush_req), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  localparam int NV = 6;
  localparam logic [31:0] V_MASK [NV] = '{32'h0000_004A, 32'hFFFF_FFFF, 32'h0000_0003,
                                          32'h8000_0000, 32'hAAAA_AAAA, 32'h0001_0000};
  localparam int V_LIM [NV] = '{47, 47, 5, 1, 0, 60};
  localparam int V_FRM [NV] = '{20, 4, 12, 3, 6, 50};
  localparam bit V_STL [NV] = '{0, 0, 0, 1, 0, 1};

  int n_chk = 0, n_bad = 0;
  logic [7:0] q[$];
  logic [2:0] exp_seq = 0;
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hdr_exp(logic [2:0] s);
    logic [6:0] v;
    logic [3:0] d;
    d = {~s[0], s};
    v = {d, 3'b000};
    for (int i = 6; i >= 3; i--)
      if (v[i]) v = v ^ (7'b0001011 << (i - 3));
    return {d, v[2:0], ^{d, v[2:0]}};
  endfunction

  task automatic send_byte(logic [7:0] d, bit sof, bit fl);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d; in_sof = sof; flush_req = fl;
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; flush_req = 0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush_req = 1;
    @(posedge clk); #1;
    flush_req = 0;
  endtask

  task automatic get_cell(bit stall);
    int n;
    logic [7:0] e;
    n = q.size();
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      e = (i == 0) ? hdr_exp(exp_seq) : (i <= n) ? q[i-1] : 8'hFF;
      if (stall && (i == 0 || i == n)) begin
        repeat (2) @(negedge clk);
        check(out_valid == 1 && out_data == e, "R11 held octet", out_data, e);
      end
      out_ready = 1;
      check(out_valid == 1, "R4 valid", out_valid, 1);
      if (i == 0) begin
        check(out_data == e, "R5 header", out_data, e);
        check(out_data[7] == ~exp_seq[0], "R6 csi", out_data[7], ~exp_seq[0]);
        check(out_data[6:4] == exp_seq, "R7 seq", out_data[6:4], exp_seq);
      end else if (i <= n) begin
        check(out_data == e, "R2 R3 payload", out_data, e);
      end else begin
        check(out_data == e, "R8 R9 pad", out_data, e);
      end
      check(out_last == (i == 47), "R4 last", out_last, (i == 47));
      check(in_ready == 0, "R10 stall", in_ready, 0);
      @(posedge clk); #1;
      out_ready = 0;
    end
    q.delete();
    exp_seq = exp_seq + 3'd1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1, "R1 in_ready", in_ready, 1);

    pulse_flush();
    @(negedge clk);
    check(out_valid == 0, "R9 empty flush", out_valid, 0);

    for (int v = 0; v < NV; v++) begin
      int lim;
      slot_mask  = V_MASK[v];
      fill_limit = 6'(V_LIM[v]);
      lim = (V_LIM[v] == 0 || V_LIM[v] > 47) ? 47 : V_LIM[v];
      for (int f = 0; f < V_FRM[v]; f++) begin
        for (int s = 0; s < 32; s++) begin
          logic [7:0] d;
          d = {3'(f), 5'(s)};
          send_byte(d, s == 0, 0);
          if (s != 0 && V_MASK[v][s]) begin
            q.push_back(d);
            if (q.size() == lim) get_cell(V_STL[v]);
          end
        end
      end
      if (q.size() > 0) begin
        pulse_flush();
        get_cell(0);
      end
    end

    slot_mask  = 32'h0000_004A;
    fill_limit = 6'd47;
    send_byte(8'hE0, 1, 0);
    send_byte(8'h5A, 0, 1);
    q.push_back(8'h5A);
    get_cell(1);
    @(negedge clk);
    check(in_ready == 1, "R10 ready after cell", in_ready, 1);

    finish_run();
  end
endmodule